// File: doc/BRIEF.md
# Eight-Digit Multiplexed Seven-Segment Scanner

This block shows an eight-digit decimal value on eight common-anode seven-segment digits that share one set of segment lines. It holds one digit enabled at a time and steps through the digits in a ring at a rate set by an internal prescaler. The default prescaler gives about 1.2 kHz from a 200 MHz clock, so every digit is refreshed about 150 times a second. The value arrives as a held parallel BCD word from an upstream latch. The word is a level and not a stream, so it has no handshake: the scanner reads whichever nibble belongs to the enabled digit. It has no back-pressure, and a change to the word shows on the next digit that is scanned.

The nibble of the enabled digit is decoded to an active-low segment pattern. Zeros to the left of the first significant digit are kept dark by a blanking chain that runs from the most significant digit down. The least significant digit always shows, so a value of zero reads as a single "0". Before the select moves to another digit, the segment lines are held dark for one clock so that the old pattern cannot ghost onto the new digit. For a set number of scan ticks after reset, every segment of every digit is lit as a lamp test. The lamp test overrides the zero blanking.

Top module: `digit_scan_drv`

## Requirements
- R1: `dig_sel` is one-hot at all times. Bit i enables digit i, and digit i displays `bcd_value[4*i+3:4*i]` (digit 0 is least significant). After reset digit 0 is enabled. The select moves one place up, wrapping from the top digit to digit 0, on the rising edge that follows each gap cycle.
- R2: A gap cycle, with `seg_n` all ones and the select unchanged, is present in the cycles after rising edge number CLK_DIV, 2*CLK_DIV, 3*CLK_DIV and so on, counted from the release of reset. The select never changes except straight after a gap cycle.
- R3: `seg_n` bit 0 is segment a and bit 6 is segment g, and a 0 lights a segment. Codes 0 to 9 light, as gfedcba: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R4: A nibble code from 10 to 15 leaves its digit fully dark (`seg_n` all ones). Such a code counts as non-zero for the blanking chain.
- R5: Outside the lamp test, a digit above digit 0 is dark when its nibble is 0 and every more significant nibble is also 0.
- R6: Digit 0 is never blanked for leading zeros. A zero there shows the pattern of 0.
- R7: The lamp test covers the cycles before rising edge LAMP_TICKS*CLK_DIV after reset release. During it, `seg_n` is all zeros in every non-gap cycle, whatever `bcd_value` holds, and the digits still scan.
- R8: While reset is held, and in the cycle after its release, `dig_sel` enables digit 0 only and `seg_n` is all zeros (lamp test).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_value | input | NUM_DIGITS*4 | Held BCD value, one nibble per digit, digit 0 in the low nibble |
| seg_n | output | 7 | Shared active-low segment lines, bit 0 = a to bit 6 = g |
| dig_sel | output | NUM_DIGITS | One-hot digit enable, active high |

## Verification
The checker watches on every cycle that the select stays one-hot, moves only to the next digit in the ring and only straight after a dark gap cycle. It also checks that the lamp test yields only fully lit or fully dark segment words, and that a zero top nibble keeps the top digit dark while digit 0 still shows a zero. The exact cycles of the gap and of the end of the lamp test, the full decode table, the handling of invalid codes, and blanking that stops at the first significant digit in the middle of the word are shown only by the bench. The bench compares every cycle against a model built from the edge counts.

// File: rtl/digit_scan_pkg.sv
package digit_scan_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK_N = '1;
  localparam seg_t SEG_FULL_N = '0;

  // Active-high gfedcba pattern for a nibble; invalid codes light nothing.
  function automatic seg_t nib_to_seg(input logic [3:0] nib);
    seg_t s;
    case (nib)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int CLK_DIV = 165563
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lamp_timer.sv
module lamp_timer #(
  parameter int LAMP_TICKS = 604
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic lamp_on
);
  localparam int LW = $clog2(LAMP_TICKS + 1);
  localparam logic [LW-1:0] LIMIT = LW'(LAMP_TICKS);

  logic [LW-1:0] cnt_q;

  assign lamp_on = (cnt_q != LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (tick && lamp_on) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/digit_sequencer.sv
module digit_sequencer #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  output logic                 gap,
  output logic [$clog2(N)-1:0] idx,
  output logic [N-1:0]         dig_sel
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] TOP = IW'(N - 1);

  logic          gap_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
      idx_q <= '0;
    end else begin
      gap_q <= tick;
      if (gap_q) idx_q <= (idx_q == TOP) ? '0 : idx_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign dig_sel[i] = (idx_q == IW'(i));
  end

  assign gap = gap_q;
  assign idx = idx_q;
endmodule

// File: rtl/zero_blank_chain.sv
module zero_blank_chain #(
  parameter int N = 8
) (
  input  logic [N*4-1:0] bcd,
  output logic [N-1:0]   blank
);
  logic [N-1:0] chain;

  assign chain[N-1] = (bcd[N*4-1 -: 4] == 4'd0);
  for (genvar i = N - 2; i >= 0; i--) begin : g_chain
    assign chain[i] = chain[i+1] && (bcd[i*4 +: 4] == 4'd0);
  end

  assign blank = {chain[N-1:1], 1'b0};
endmodule

// File: rtl/digit_scan_drv.sv
module digit_scan_drv #(
  parameter int NUM_DIGITS = 8,
  parameter int CLK_DIV    = 165563,
  parameter int LAMP_TICKS = 604
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_DIGITS*4-1:0] bcd_value,
  output logic [6:0]              seg_n,
  output logic [NUM_DIGITS-1:0]   dig_sel
);
  import digit_scan_pkg::*;

  localparam int IW = $clog2(NUM_DIGITS);

  logic                  tick;
  logic                  lamp_on;
  logic                  gap;
  logic [IW-1:0]         idx;
  logic [NUM_DIGITS-1:0] blank;
  logic [3:0]            nibs [NUM_DIGITS];

  scan_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lamp_timer #(.LAMP_TICKS(LAMP_TICKS)) lamp_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lamp_on(lamp_on)
  );

  digit_sequencer #(.N(NUM_DIGITS)) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .gap(gap), .idx(idx), .dig_sel(dig_sel)
  );

  zero_blank_chain #(.N(NUM_DIGITS)) blank_i (
    .bcd(bcd_value), .blank(blank)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_nib
    assign nibs[i] = bcd_value[i*4 +: 4];
  end

  always_comb begin
    if (gap)             seg_n = SEG_DARK_N;
    else if (lamp_on)    seg_n = SEG_FULL_N;
    else if (blank[idx]) seg_n = SEG_DARK_N;
    else                 seg_n = ~nib_to_seg(nibs[idx]);
  end
endmodule

// File: rtl/digit_scan_chk.sv
module digit_scan_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [6:0]   seg_n,
  input logic [N-1:0] dig_sel,
  input logic [3:0]   lsd_nib,
  input logic [3:0]   msd_nib,
  input logic         lamp_on,
  input logic         gap
);
  p_onehot_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dig_sel) == 1);

  p_ring_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dig_sel) |-> dig_sel == {$past(dig_sel[N-2:0]), $past(dig_sel[N-1])});

  p_gap_before_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dig_sel) |-> $past(seg_n) == 7'h7F);

  p_lamp_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_on |-> (seg_n == 7'h00 || seg_n == 7'h7F));

  p_msd_zero_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel[N-1] && !lamp_on && msd_nib == 4'd0) |-> seg_n == 7'h7F);

  p_lsd_zero_shown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel[0] && !lamp_on && !gap && lsd_nib == 4'd0) |-> seg_n == 7'b1000000);
endmodule

bind digit_scan_drv digit_scan_chk #(.N(NUM_DIGITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .seg_n(seg_n), .dig_sel(dig_sel),
  .lsd_nib(bcd_value[3:0]), .msd_nib(bcd_value[NUM_DIGITS*4-1 -: 4]),
  .lamp_on(lamp_on), .gap(gap)
);

// File: tb/digit_scan_drv_tb_top.sv
`timescale 1ns/1ps
module digit_scan_drv_tb_top;
  localparam int N = 8;
  localparam int D = 4;
  localparam int L = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N*4-1:0] bcd = '0;
  logic [6:0]   seg_n;
  logic [N-1:0] dig_sel;

  int k = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  digit_scan_drv #(.NUM_DIGITS(N), .CLK_DIV(D), .LAMP_TICKS(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .bcd_value(bcd), .seg_n(seg_n), .dig_sel(dig_sel)
  );

  function automatic logic [6:0] seg_on(input logic [3:0] n);
    case (n)
      4'd0: return 7'b0111111;  4'd1: return 7'b0000110;
      4'd2: return 7'b1011011;  4'd3: return 7'b1001111;
      4'd4: return 7'b1100110;  4'd5: return 7'b1101101;
      4'd6: return 7'b1111101;  4'd7: return 7'b0000111;
      4'd8: return 7'b1111111;  4'd9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic int exp_idx(input int kk);
    return (kk == 0) ? 0 : ((kk - 1) / D) % N;
  endfunction

  task automatic check_cycle();
    int i = exp_idx(k);
    bit gp = (k > 0) && (k % D == 0);
    bit lamp = (k / D) < L;
    logic [3:0] nib = bcd[i*4 +: 4];
    bit lead = (i != 0);
    logic [6:0] es;
    logic [N-1:0] esel = '0;
    string tag;
    for (int j = i; j < N; j++) if (bcd[j*4 +: 4] != 4'd0) lead = 0;
    esel[i] = 1'b1;
    if (k == 0)        begin tag = "R8"; es = 7'h00; end
    else if (gp)       begin tag = "R2"; es = 7'h7F; end
    else if (lamp)     begin tag = "R7"; es = 7'h00; end
    else if (lead)     begin tag = "R5"; es = 7'h7F; end
    else if (nib > 9)  begin tag = "R4"; es = 7'h7F; end
    else if (i == 0 && nib == 0) begin tag = "R6"; es = ~seg_on(nib); end
    else               begin tag = "R3"; es = ~seg_on(nib); end
    checks++;
    if (seg_n !== es) begin
      errors++;
      $display("FAIL %s k=%0d seg_n actual=%b expected=%b", tag, k, seg_n, es);
    end
    checks++;
    if (dig_sel !== esel) begin
      errors++;
      $display("FAIL R1 k=%0d dig_sel actual=%b expected=%b", k, dig_sel, esel);
    end
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      #1;
      check_cycle();
    end
  endtask

  task automatic show(input logic [N*4-1:0] v);
    @(negedge clk);
    bcd = v;
    #1;
    check_cycle();
    run(2 * N * D);
  endtask

  initial begin
    logic [N*4-1:0] v;
    int z;
    int d;
    void'($urandom(32'd1208));
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    check_cycle();             // R8 during reset
    rst_n = 1'b1;
    #1;
    check_cycle();             // R8 just after release
    bcd = 32'h0000_0000;       // R7: lamp must override blanking
    run(L * D + 4);
    show(32'h0000_0000);       // R6: single zero
    show(32'h1000_0000);       // R5: inner zeros kept
    show(32'h0000_0305);       // R5 with inner zero
    show(32'h8765_4321);       // R3
    show(32'h0000_9A00);       // R4 invalid code breaks chain
    show(32'hF000_0000);       // R4 at top
    for (int r = 0; r < 30; r++) begin
      v = '0;
      z = $urandom % 9;
      for (int i = 0; i < N; i++) begin
        d = ($urandom % 8 == 0) ? 10 + $urandom % 6 : $urandom % 10;
        if (i >= N - z) d = 0;
        v[i*4 +: 4] = 4'(d);
      end
      show(v);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule